// File: doc/BRIEF.md
# Frequency Scan Sequencer

This block drives the tuning word of a phase-accumulator synthesizer through a stepped frequency scan. Software writes four settings through a small parallel write port: the first frequency, the increment added at each step, how many increments make up the scan, and how long each frequency is held. It also selects the pacing and sync modes. A recognized rising edge on the control input starts the scan. The settings are copied into working registers at that moment, and the first tuning word appears a fixed number of cycles later.

The block paces each step in one of two ways. In automatic mode a dwell timer counts master clock cycles, scaled by a selectable power-of-four multiplier. In external mode every recognized control edge advances the word by one step. A one-cycle phase-clear pulse goes with the first word of a scan so that the synthesizer starts from a known phase. Later steps only change the word and leave the phase alone.

After the last increment the final word stays on the output. It is cleared only by the synchronous scan-clear input or by the chip reset. A sync output gives a one-cycle pulse either after every increment or once at the end of the scan.

Top module: `freq_scan_seq`

## Requirements
- R1: Writes use `wr_addr` to select the setting: 0 = start word, 1 = step word, 2 = increment count in `wr_data[NW-1:0]`, 3 = timing and mode. In the timing-and-mode setting, bits `[DW-1:0]` hold the dwell value, bits `[DW+1:DW]` the multiplier exponent m, bit `DW+2` external pacing (1) and bit `DW+3` end-of-scan sync (1).
- R2: From idle, a control input that is sampled high on two consecutive rising clock edges (edges k and k+1) starts a scan. `ftw_valid` goes high and `ftw` equals the start word after edge k+8.
- R3: In automatic mode each frequency is held for D = max(dwell,1)·4^m cycles. After that the word advances by the step value, modulo 2^FW.
- R4: In external mode the dwell timer is not used. Each recognized control pulse, sampled high at edges j and j+1, advances the word after edge j+2.
- R5: After the programmed number of increments the final word stays unchanged until `scan_clr` or `rst_n`. With a count of 0 the start word is held.
- R6: With per-step sync selected, `sync_out` pulses for one cycle, one cycle after each increment of the word. It does not pulse for the first word.
- R7: With end-of-scan sync selected, `sync_out` pulses once, two cycles after the final word appears. The final word is the first word when the count is 0.
- R8: `phase_clr` is a one-cycle pulse in the same cycle as the first word of a scan and never accompanies later steps.
- R9: A control pulse seen on only one clock edge neither starts nor advances a scan.
- R10: `scan_active` is high from edge k+2 until the final increment takes effect. `scan_clr` returns the block to idle, with `ftw_valid`, `scan_active`, `sync_out` and `ftw` all 0 after the next edge.
- R11: After reset all outputs are 0.
- R12: Writes made while a scan runs do not change that scan. They are used by the next scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 2 | Setting select |
| wr_data | input | FW | Write data |
| ctrl_in | input | 1 | Start / step control, synchronous to clk |
| scan_clr | input | 1 | Synchronous return to idle |
| ftw | output | FW | Frequency tuning word |
| ftw_valid | output | 1 | Tuning word is being driven |
| phase_clr | output | 1 | Phase accumulator clear, first word only |
| sync_out | output | 1 | Step or end-of-scan sync pulse |
| scan_active | output | 1 | Scan in progress |

## Verification
The bench counts the cycles from the start edge to the first word. An extra or missing register in the start path would move the word's arrival, the phase-clear pulse and the active window off the predicted cycle. It covers a dwell value of zero, which a wrong design would read as a very long or endless hold. It runs a start word near full scale, where a design that did not wrap modulo 2^FW would give wrong words. It also covers a zero count, where a design could wander past the start word or never give the end-of-scan pulse. Finally it tries one-cycle control pulses, edges in external mode, and writes made in the middle of a scan. A weak filter or a live shadow path would show up there as extra steps or as a scan whose values change while it runs.

// File: rtl/fscan_pkg.sv
package fscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } scan_st_e;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_STEP  = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;
  localparam logic [1:0] SEL_TIME  = 2'd3;
endpackage

// File: rtl/fscan_cfg_regs.sv
module fscan_cfg_regs
  import fscan_pkg::*;
#(
  parameter int FW = 24,
  parameter int NW = 12,
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [FW-1:0] wr_data,
  output logic [FW-1:0] sh_start,
  output logic [FW-1:0] sh_step,
  output logic [NW-1:0] sh_count,
  output logic [DW-1:0] sh_dwell,
  output logic [1:0]    sh_mult,
  output logic          sh_ext,
  output logic          sh_eos
);
  logic en_start, en_step, en_count, en_time;

  always_comb begin
    en_start = wr_en && (wr_addr == SEL_START);
    en_step  = wr_en && (wr_addr == SEL_STEP);
    en_count = wr_en && (wr_addr == SEL_COUNT);
    en_time  = wr_en && (wr_addr == SEL_TIME);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_start <= '0;
      sh_step  <= '0;
      sh_count <= '0;
      sh_dwell <= '0;
      sh_mult  <= '0;
      sh_ext   <= 1'b0;
      sh_eos   <= 1'b0;
    end else begin
      if (en_start) sh_start <= wr_data;
      if (en_step)  sh_step  <= wr_data;
      if (en_count) sh_count <= wr_data[NW-1:0];
      if (en_time) begin
        sh_dwell <= wr_data[DW-1:0];
        sh_mult  <= wr_data[DW+1:DW];
        sh_ext   <= wr_data[DW+2];
        sh_eos   <= wr_data[DW+3];
      end
    end
  end
endmodule

// File: rtl/fscan_ctrl_filt.sv
module fscan_ctrl_filt #(
  parameter int MIN_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_in,
  output logic edge_o
);
  logic [MIN_W-1:0] smp;
  logic [MIN_W-1:0] smp_n;
  logic             lvl, lvl_n;
  logic             all_hi, all_lo;

  generate
    if (MIN_W == 1) begin : g_one
      assign smp_n = ctrl_in;
    end else begin : g_many
      assign smp_n = {smp[MIN_W-2:0], ctrl_in};
    end
  endgenerate

  always_comb begin
    all_hi = &smp;
    all_lo = ~|smp;
    lvl_n  = lvl;
    if (all_hi)      lvl_n = 1'b1;
    else if (all_lo) lvl_n = 1'b0;
    edge_o = all_hi && !lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp <= '0;
      lvl <= 1'b0;
    end else begin
      smp <= smp_n;
      lvl <= lvl_n;
    end
  end
endmodule

// File: rtl/fscan_dwell.sv
module fscan_dwell #(
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          en,
  input  logic [DW-1:0] dwell,
  input  logic [1:0]    mult,
  output logic          expire
);
  localparam int CW = DW + 6;

  logic [CW-1:0] cnt, cnt_n, base, reload;

  always_comb begin
    base   = (dwell == '0) ? CW'(1) : CW'(dwell);
    reload = (base << {mult, 1'b0}) - CW'(1);
    expire = en && (cnt == '0);
    cnt_n  = cnt;
    if (load)                 cnt_n = reload;
    else if (en && cnt == '0) cnt_n = reload;
    else if (en)              cnt_n = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/fscan_sync.sv
module fscan_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic eos_mode,
  input  logic step_ev,
  input  logic last_ev,
  output logic sync_o
);
  logic step_q, last_q1, last_q2;
  logic step_n, last_n1, last_n2, sync_n;

  always_comb begin
    step_n  = clr ? 1'b0 : step_ev;
    last_n1 = clr ? 1'b0 : last_ev;
    last_n2 = clr ? 1'b0 : last_q1;
    sync_n  = clr ? 1'b0 : (eos_mode ? last_q2 : step_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= 1'b0;
      last_q1 <= 1'b0;
      last_q2 <= 1'b0;
      sync_o  <= 1'b0;
    end else begin
      step_q  <= step_n;
      last_q1 <= last_n1;
      last_q2 <= last_n2;
      sync_o  <= sync_n;
    end
  end
endmodule

// File: rtl/freq_scan_seq.sv
module freq_scan_seq
  import fscan_pkg::*;
#(
  parameter int FW        = 24,
  parameter int NW        = 12,
  parameter int DW        = 11,
  parameter int MIN_W     = 2,
  parameter int START_DLY = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [FW-1:0] wr_data,
  input  logic          ctrl_in,
  input  logic          scan_clr,
  output logic [FW-1:0] ftw,
  output logic          ftw_valid,
  output logic          phase_clr,
  output logic          sync_out,
  output logic          scan_active
);
  localparam int DLYW = $clog2(START_DLY + 1);

  logic [FW-1:0] sh_start, sh_step;
  logic [NW-1:0] sh_count;
  logic [DW-1:0] sh_dwell;
  logic [1:0]    sh_mult;
  logic          sh_ext, sh_eos;

  logic [FW-1:0] w_start, w_step;
  logic [NW-1:0] w_count;
  logic [DW-1:0] w_dwell;
  logic [1:0]    w_mult;
  logic          w_ext, w_eos;

  scan_st_e      st, st_n;
  logic [DLYW-1:0] dly, dly_n;
  logic [NW-1:0] left, left_n;
  logic [FW-1:0] ftw_n;
  logic          valid_n, phc_n;
  logic          cap_en, tmr_load, tmr_en, tmr_exp;
  logic          start_edge, adv, step_ev, last_ev;

  fscan_cfg_regs #(.FW(FW), .NW(NW), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sh_start(sh_start), .sh_step(sh_step),
    .sh_count(sh_count), .sh_dwell(sh_dwell), .sh_mult(sh_mult),
    .sh_ext(sh_ext), .sh_eos(sh_eos)
  );

  fscan_ctrl_filt #(.MIN_W(MIN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .ctrl_in(ctrl_in), .edge_o(start_edge)
  );

  fscan_dwell #(.DW(DW)) u_dwell (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .en(tmr_en),
    .dwell(w_dwell), .mult(w_mult), .expire(tmr_exp)
  );

  fscan_sync u_sync (
    .clk(clk), .rst_n(rst_n), .clr(scan_clr), .eos_mode(w_eos),
    .step_ev(step_ev), .last_ev(last_ev), .sync_o(sync_out)
  );

  // next-state logic
  always_comb begin
    st_n     = st;
    dly_n    = dly;
    left_n   = left;
    ftw_n    = ftw;
    valid_n  = ftw_valid;
    phc_n    = 1'b0;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    step_ev  = 1'b0;
    last_ev  = 1'b0;
    tmr_en   = (st == ST_RUN) && !w_ext;
    adv      = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start_edge) begin
          st_n   = ST_LOAD;
          dly_n  = DLYW'(START_DLY - 1);
          cap_en = 1'b1;
        end
      end
      ST_LOAD: begin
        if (dly == '0) begin
          st_n     = (w_count == '0) ? ST_DONE : ST_RUN;
          ftw_n    = w_start;
          valid_n  = 1'b1;
          phc_n    = 1'b1;
          left_n   = w_count;
          tmr_load = 1'b1;
          last_ev  = (w_count == '0);
        end else begin
          dly_n = dly - DLYW'(1);
        end
      end
      ST_RUN: begin
        adv = w_ext ? start_edge : tmr_exp;
        if (adv) begin
          ftw_n   = ftw + w_step;
          left_n  = left - NW'(1);
          step_ev = 1'b1;
          if (left == NW'(1)) begin
            st_n    = ST_DONE;
            last_ev = 1'b1;
          end
        end
      end
      ST_DONE: begin
        st_n = ST_DONE;
      end
      default: st_n = ST_IDLE;
    endcase
    if (scan_clr) begin
      st_n    = ST_IDLE;
      ftw_n   = '0;
      valid_n = 1'b0;
      phc_n   = 1'b0;
      cap_en  = 1'b0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      dly       <= '0;
      left      <= '0;
      ftw       <= '0;
      ftw_valid <= 1'b0;
      phase_clr <= 1'b0;
    end else begin
      st        <= st_n;
      dly       <= dly_n;
      left      <= left_n;
      ftw       <= ftw_n;
      ftw_valid <= valid_n;
      phase_clr <= phc_n;
    end
  end

  // working copies, captured only at scan start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_start <= '0;
      w_step  <= '0;
      w_count <= '0;
      w_dwell <= '0;
      w_mult  <= '0;
      w_ext   <= 1'b0;
      w_eos   <= 1'b0;
    end else if (cap_en) begin
      w_start <= sh_start;
      w_step  <= sh_step;
      w_count <= sh_count;
      w_dwell <= sh_dwell;
      w_mult  <= sh_mult;
      w_ext   <= sh_ext;
      w_eos   <= sh_eos;
    end
  end

  assign scan_active = (st == ST_LOAD) || (st == ST_RUN);
endmodule

// File: rtl/fscan_chk.sv
module fscan_chk #(
  parameter int FW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scan_clr,
  input logic [FW-1:0] ftw,
  input logic          ftw_valid,
  input logic          phase_clr,
  input logic          sync_out,
  input logic          scan_active
);
  p_hold_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw_valid && !scan_clr) |=> ftw_valid);

  p_final_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw_valid && !scan_active && !scan_clr) |=> $stable(ftw));

  p_step_in_scan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw_valid && $past(ftw_valid) && !$stable(ftw)) |-> $past(scan_active));

  p_sync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out);

  p_phase_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |-> $rose(ftw_valid));

  p_clr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_clr |=> (!ftw_valid && !scan_active && !sync_out && ftw == '0));

  p_quiet_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ftw_valid |-> !sync_out);
endmodule

bind freq_scan_seq fscan_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_clr(scan_clr), .ftw(ftw),
  .ftw_valid(ftw_valid), .phase_clr(phase_clr), .sync_out(sync_out),
  .scan_active(scan_active)
);

// File: tb/sim_freq_scan_seq.sv
module sim_freq_scan_seq;
  localparam int FW = 24;
  localparam int NW = 12;
  localparam int DW = 11;
  localparam int NV = 5;

  // vector table: start, step, count, dwell, mult, ext, eos
  localparam int V_START [NV] = '{1000, 24'hFFFFF0, 500, 77, 40};
  localparam int V_STEP  [NV] = '{10, 8, 3, 5, 100};
  localparam int V_CNT   [NV] = '{3, 4, 2, 0, 2};
  localparam int V_DWELL [NV] = '{2, 0, 1, 3, 3};
  localparam int V_MULT  [NV] = '{0, 0, 1, 0, 2};
  localparam int V_EOS   [NV] = '{0, 1, 0, 1, 0};

  logic          clk, rst_n, wr_en, ctrl_in, scan_clr;
  logic [1:0]    wr_addr;
  logic [FW-1:0] wr_data, ftw;
  logic          ftw_valid, phase_clr, sync_out, scan_active;
  int            total, bad;

  freq_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_in(ctrl_in), .scan_clr(scan_clr),
    .ftw(ftw), .ftw_valid(ftw_valid), .phase_clr(phase_clr),
    .sync_out(sync_out), .scan_active(scan_active)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = FW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_scan();
    @(negedge clk);
    scan_clr = 1'b1;
    @(negedge clk);
    scan_clr = 1'b0;
  endtask

  // drive ctrl high for w sampling edges; returns at the negedge after edge k+w-1
  task automatic pulse(input int w);
    @(negedge clk);
    ctrl_in = 1'b1;
    for (int i = 0; i < w; i++) @(negedge clk);
    ctrl_in = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0;
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ctrl_in = 1'b0; scan_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk({ftw_valid, phase_clr, sync_out, scan_active} == 4'b0 && ftw == '0,
        "R11 reset outputs", {ftw_valid, phase_clr, sync_out, scan_active}, 0);

    // table walk: R1 R2 R3 R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      int d, cnt, last;
      d    = ((V_DWELL[v] == 0) ? 1 : V_DWELL[v]) << (2 * V_MULT[v]);
      cnt  = V_CNT[v];
      last = 8 + cnt * d;
      wr(2'd0, V_START[v]);
      wr(2'd1, V_STEP[v]);
      wr(2'd2, cnt);
      wr(2'd3, (V_EOS[v] << (DW + 3)) | (V_MULT[v] << DW) | V_DWELL[v]);
      clr_scan();
      @(negedge clk);
      ctrl_in = 1'b1;
      for (int t = 0; t <= last + 6; t++) begin
        logic [FW-1:0] e_ftw;
        bit e_val, e_act, e_syn, e_phc;
        int n;
        @(negedge clk);
        if (t == 1) ctrl_in = 1'b0;
        n = (t < 8) ? 0 : (t - 8) / d;
        if (n > cnt) n = cnt;
        e_val = (t >= 8);
        e_ftw = e_val ? FW'(V_START[v] + n * V_STEP[v]) : '0;
        e_act = (t >= 2) && (t < last);
        e_phc = (t == 8);
        if (V_EOS[v] != 0) e_syn = (t == last + 2);
        else e_syn = (t >= 9) && ((t - 9) % d == 0) && ((t - 9) / d >= 1) && ((t - 9) / d <= cnt);
        chk(ftw == e_ftw, "R2 R3 R5 word", ftw, e_ftw);
        chk(ftw_valid == e_val, "R2 valid", ftw_valid, e_val);
        chk(scan_active == e_act, "R10 active", scan_active, e_act);
        chk(phase_clr == e_phc, "R8 phase", phase_clr, e_phc);
        chk(sync_out == e_syn, V_EOS[v] != 0 ? "R7 sync" : "R6 sync", sync_out, e_syn);
      end
    end

    // R10 scan_clr returns to idle
    clr_scan();
    chk(!ftw_valid && !scan_active && ftw == '0, "R10 clear", {ftw_valid, scan_active}, 0);

    // R9 single-edge pulse from idle does not start
    pulse(1);
    wait_n(12);
    chk(!scan_active && !ftw_valid, "R9 short start", {scan_active, ftw_valid}, 0);

    // external mode: R4 R9 R12
    wr(2'd0, 200);
    wr(2'd1, 5);
    wr(2'd2, 2);
    wr(2'd3, (1 << (DW + 2)) | 1);
    pulse(2);
    wait_n(7);
    chk(ftw_valid && ftw == 200 && phase_clr, "R4 ext first word", ftw, 200);
    wait_n(20);
    chk(ftw == 200 && scan_active, "R4 ext no dwell step", ftw, 200);
    wr(2'd0, 999);
    chk(ftw == 200, "R12 write mid-scan", ftw, 200);
    pulse(2);
    chk(ftw == 200, "R4 ext before step", ftw, 200);
    @(negedge clk);
    chk(ftw == 205 && !sync_out, "R4 ext step", ftw, 205);
    @(negedge clk);
    chk(sync_out, "R6 ext sync", sync_out, 1);
    wait_n(4);
    pulse(1);
    wait_n(6);
    chk(ftw == 205, "R9 short step", ftw, 205);
    pulse(2);
    @(negedge clk);
    chk(ftw == 210 && !scan_active, "R4 R10 ext last", ftw, 210);
    wait_n(4);
    pulse(2);
    wait_n(4);
    chk(ftw == 210 && ftw_valid, "R5 hold after end", ftw, 210);

    // R12 the mid-scan write applies to the next scan
    clr_scan();
    pulse(2);
    wait_n(7);
    chk(ftw == 999 && phase_clr, "R12 next scan start", ftw, 999);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule